// File: doc/BRIEF.md
# Protected Configuration Register Bank

This block is the byte-wide control register bank of a multichannel converter. A serial command decoder in front of it presents an 8-bit address, an 8-bit write value and a write strobe. The bank answers every address with combinational read data. Its stored fields are exported as plain outputs to the rest of the converter. The protocol framing, the CRC computation and the analog functions all sit outside. Three events enter as single-cycle pulses: an input-CRC mismatch, a supply brown-out and a configuration-load fault.

Write access is conditional. A sticky CRC-error flag restricts writes to the status and general-control addresses until software clears the flag. A key register opens or closes a three-byte diagnostics window. The status byte combines several kinds of bit: a constant one, a live sequencer indication, sticky fault flags and write-one-to-clear flags. The general-control byte holds a software-reset command and a calibration command. Both commands clear themselves.

Top module: `cfg_regbank`

## Requirements
- R1: After the asynchronous reset, address 0x00 reads 0x81 with `seq_active_i` low, address 0x04 reads 0x01, and every other address reads 0x00.
- R2: Address 0x00 reads as {1, `seq_active_i`, 000, config-fault, CRC-error, brown-out} from bit 7 down to bit 0. A pulse on `cfg_fault_i`, `crc_err_i` or `brownout_i` sets its flag at the next edge. If a clear arrives in the same cycle as a pulse, the pulse wins.
- R3: A write to 0x00 clears the CRC-error flag when bit 1 is 1 and clears the brown-out flag when bit 0 is 1. A 0 in either bit leaves that flag unchanged. The config-fault flag is not cleared by any write to 0x00.
- R4: While the CRC-error flag is set, a write to any address other than 0x00 and 0x01 changes nothing.
- R5: Writing 0x01 with bit 0 set returns every register to its R1 value at the next edge. It also clears the CRC-error and config-fault flags, sets the brown-out flag and stops calibration. The other bits of that write are discarded, and bit 0 of 0x01 always reads 0.
- R6: Writing 0x01 with bit 1 set and bit 0 clear starts calibration. Bit 1 of 0x01 and `cal_busy_o` then read 1 for exactly `CAL_CYCLES` (default 16) cycles. A further request while calibration is busy neither restarts nor extends it.
- R7: Writes to 0xC0, 0xC1 and 0xC2 take effect only while the key register at 0xBF holds `UNLOCK_KEY` (default 0x96). Any other key value relocks the window.
- R8: Only these bits can be written; all others read 0 and ignore writes: 0x01 mask 0xCC, 0x02 mask 0xB3, 0x03 mask 0x07, 0x04 mask 0x1F, 0x10 mask 0x13, 0x11 mask 0x0F, 0xC0 mask 0x11. Addresses 0x05, 0x07, 0x09, 0x0B, 0x12, 0xBF, 0xC1 and 0xC2 take all 8 bits.
- R9: An address outside the map reads 0x00 and ignores writes. Address 0x0D is read-only.
- R10: `rdata_o` follows `addr_i` within the same cycle. An accepted write is visible from the cycle after its edge. Address 0x0D returns `gpi_i` as it currently stands.
- R11: Each field output equals its register bits. 0x01: 7 ref, 6 crc, 3 range, 2 force. 0x02: 7 fixed pattern, 5:4 append, 1:0 spi mode. 0x03: 2:0 osr. 0x04: 4 osc, 3:0 divider. 0x05/0x07/0x09/0x0B: pin, direction, drive, value. 0x10: 4 start, 1:0 mode. 0x11: 3:0 channel. 0x12: auto channels. 0xC0: bit 0 bit-walk, bit 4 test voltage. 0xC1/0xC2: sample low/high. `vtest_en_o` is forced to 0 while bit-walk is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| crc_err_i | input | 1 | Input-CRC mismatch pulse |
| brownout_i | input | 1 | Brown-out pulse |
| cfg_fault_i | input | 1 | Configuration-load fault pulse |
| seq_active_i | input | 1 | Sequencer running |
| gpi_i | input | 8 | General-purpose input levels |
| ref_en_o | output | 1 | Internal reference enable |
| crc_en_o | output | 1 | Interface CRC enable |
| range_o | output | 1 | Input range select |
| ch_force_o | output | 1 | Force all channels analog |
| cal_busy_o | output | 1 | Offset calibration in progress |
| fix_pat_o | output | 1 | Fixed output pattern |
| append_sel_o | output | 2 | Appended tag select |
| spi_mode_o | output | 2 | Serial clock polarity and phase |
| osr_o | output | 3 | Averaging ratio code |
| osc_sel_o | output | 1 | Oscillator select |
| clk_div_o | output | 4 | Sampling clock divider |
| pin_cfg_o | output | 8 | Analog or digital per channel |
| gpio_dir_o | output | 8 | Digital direction |
| gpo_drive_o | output | 8 | Output driver type |
| gpo_val_o | output | 8 | Output levels |
| seq_start_o | output | 1 | Start channel sequencing |
| seq_mode_o | output | 2 | Sequencing mode |
| manual_ch_o | output | 4 | Manual channel number |
| auto_ch_o | output | 8 | Auto-scan channel enables |
| bitwalk_en_o | output | 1 | Bit-walk diagnostic enable |
| vtest_en_o | output | 1 | Test-voltage diagnostic enable |
| bit_sample_o | output | 16 | Diagnostic bit-sample pattern |

## Verification
Every stored result passes through one register stage. A write, a flag clear, a flag pulse or a software reset therefore shows on `rdata_o` and on the field outputs one edge after the cycle that carries it. Read data itself is combinational on the address. Calibration holds its busy indication for the 16 cycles that follow the request edge. The bench applies each stimulus for one full cycle. It advances its behavioural model at that cycle's rising edge and compares all outputs at the following falling edge. Cycle counts for calibration are taken from those same falling-edge samples.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
  localparam int DW   = 8;
  localparam int NREG = 15;

  localparam logic [DW-1:0] A_STATUS  = 8'h00;
  localparam logic [DW-1:0] A_GEN     = 8'h01;
  localparam logic [DW-1:0] A_GPI     = 8'h0D;
  localparam logic [DW-1:0] A_DIAG_LO = 8'hC0;
  localparam logic [DW-1:0] A_DIAG_HI = 8'hC2;

  localparam int I_GEN  = 0;
  localparam int I_DATA = 1;
  localparam int I_OSR  = 2;
  localparam int I_OPM  = 3;
  localparam int I_PIN  = 4;
  localparam int I_DIR  = 5;
  localparam int I_DRV  = 6;
  localparam int I_GPO  = 7;
  localparam int I_SEQ  = 8;
  localparam int I_MCH  = 9;
  localparam int I_ACH  = 10;
  localparam int I_KEY  = 11;
  localparam int I_DEN  = 12;
  localparam int I_BSL  = 13;
  localparam int I_BSH  = 14;

  function automatic logic [DW-1:0] reg_addr(input int i);
    case (i)
      I_GEN:   return 8'h01;
      I_DATA:  return 8'h02;
      I_OSR:   return 8'h03;
      I_OPM:   return 8'h04;
      I_PIN:   return 8'h05;
      I_DIR:   return 8'h07;
      I_DRV:   return 8'h09;
      I_GPO:   return 8'h0B;
      I_SEQ:   return 8'h10;
      I_MCH:   return 8'h11;
      I_ACH:   return 8'h12;
      I_KEY:   return 8'hBF;
      I_DEN:   return 8'hC0;
      I_BSL:   return 8'hC1;
      default: return 8'hC2;
    endcase
  endfunction

  // gen byte: cal (bit 1) lives in the timer, rst (bit 0) is never stored
  function automatic logic [DW-1:0] reg_mask(input int i);
    case (i)
      I_GEN:   return 8'hCC;
      I_DATA:  return 8'hB3;
      I_OSR:   return 8'h07;
      I_OPM:   return 8'h1F;
      I_SEQ:   return 8'h13;
      I_MCH:   return 8'h0F;
      I_DEN:   return 8'h11;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_rst(input int i);
    return (i == I_OPM) ? 8'h01 : 8'h00;
  endfunction

  function automatic bit is_diag(input logic [DW-1:0] a);
    return (a >= A_DIAG_LO) && (a <= A_DIAG_HI);
  endfunction
endpackage

// File: rtl/cfg_wr_gate.sv
module cfg_wr_gate
  import cfg_regbank_pkg::*;
#(
  parameter logic [DW-1:0] UNLOCK_KEY = 8'h96
) (
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [1:0]    cmd_i,
  input  logic          crc_flag_i,
  input  logic [DW-1:0] key_i,
  output logic          wr_ok_o,
  output logic          diag_ok_o,
  output logic          soft_rst_o,
  output logic          cal_req_o,
  output logic          w1c_o
);
  logic gen_hit;

  // a sticky crc error leaves only status and general control writable
  assign wr_ok_o    = we_i && (!crc_flag_i || addr_i == A_STATUS || addr_i == A_GEN);
  assign diag_ok_o  = (key_i == UNLOCK_KEY);
  assign gen_hit    = wr_ok_o && (addr_i == A_GEN);
  assign soft_rst_o = gen_hit && cmd_i[0];
  assign cal_req_o  = gen_hit && cmd_i[1] && !cmd_i[0];
  assign w1c_o      = wr_ok_o && (addr_i == A_STATUS);
endmodule

// File: rtl/cfg_byte.sv
module cfg_byte
  import cfg_regbank_pkg::*;
#(
  parameter logic [DW-1:0] ADDR  = 8'h00,
  parameter logic [DW-1:0] MASK  = 8'hFF,
  parameter logic [DW-1:0] RST   = 8'h00,
  parameter bit            GATED = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          wr_ok_i,
  input  logic          diag_ok_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic hit;

  if (GATED) begin : g_gated
    assign hit = wr_ok_i && (addr_i == ADDR) && diag_ok_i;
  end else begin : g_open
    assign hit = wr_ok_i && (addr_i == ADDR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= RST;
    else if (soft_rst_i) q_o <= RST;
    else if (hit)        q_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/cfg_status.sv
module cfg_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       w1c_i,
  input  logic [1:0] w1c_data_i,
  input  logic       crc_err_i,
  input  logic       brownout_i,
  input  logic       cfg_fault_i,
  output logic       crc_flag_o,
  output logic       bor_flag_o,
  output logic       fault_flag_o
);
  // event pulses take priority over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_flag_o   <= 1'b0;
      bor_flag_o   <= 1'b1;
      fault_flag_o <= 1'b0;
    end else if (soft_rst_i) begin
      crc_flag_o   <= crc_err_i;
      bor_flag_o   <= 1'b1;
      fault_flag_o <= cfg_fault_i;
    end else begin
      crc_flag_o   <= crc_err_i   || (crc_flag_o && !(w1c_i && w1c_data_i[1]));
      bor_flag_o   <= brownout_i  || (bor_flag_o && !(w1c_i && w1c_data_i[0]));
      fault_flag_o <= cfg_fault_i || fault_flag_o;
    end
  end
endmodule

// File: rtl/cfg_cal_timer.sv
module cfg_cal_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic req_i,
  output logic busy_o
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (soft_rst_i) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (req_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter int              CAL_CYCLES = 16,
  parameter logic [DW-1:0]   UNLOCK_KEY = 8'h96
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          crc_err_i,
  input  logic          brownout_i,
  input  logic          cfg_fault_i,
  input  logic          seq_active_i,
  input  logic [7:0]    gpi_i,
  output logic          ref_en_o,
  output logic          crc_en_o,
  output logic          range_o,
  output logic          ch_force_o,
  output logic          cal_busy_o,
  output logic          fix_pat_o,
  output logic [1:0]    append_sel_o,
  output logic [1:0]    spi_mode_o,
  output logic [2:0]    osr_o,
  output logic          osc_sel_o,
  output logic [3:0]    clk_div_o,
  output logic [7:0]    pin_cfg_o,
  output logic [7:0]    gpio_dir_o,
  output logic [7:0]    gpo_drive_o,
  output logic [7:0]    gpo_val_o,
  output logic          seq_start_o,
  output logic [1:0]    seq_mode_o,
  output logic [3:0]    manual_ch_o,
  output logic [7:0]    auto_ch_o,
  output logic          bitwalk_en_o,
  output logic          vtest_en_o,
  output logic [15:0]   bit_sample_o
);
  logic [DW-1:0] q_arr [NREG];
  logic          wr_ok, diag_ok, soft_rst, cal_req, w1c;
  logic          crc_flag, bor_flag, fault_flag, cal_busy;
  logic [DW-1:0] status_byte, rd;

  cfg_wr_gate #(.UNLOCK_KEY(UNLOCK_KEY)) u_gate (
    .we_i       (we_i),
    .addr_i     (addr_i),
    .cmd_i      (wdata_i[1:0]),
    .crc_flag_i (crc_flag),
    .key_i      (q_arr[I_KEY]),
    .wr_ok_o    (wr_ok),
    .diag_ok_o  (diag_ok),
    .soft_rst_o (soft_rst),
    .cal_req_o  (cal_req),
    .w1c_o      (w1c)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    cfg_byte #(
      .ADDR  (reg_addr(g)),
      .MASK  (reg_mask(g)),
      .RST   (reg_rst(g)),
      .GATED (is_diag(reg_addr(g)))
    ) u_byte (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .wr_ok_i    (wr_ok),
      .diag_ok_i  (diag_ok),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .q_o        (q_arr[g])
    );
  end

  cfg_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst),
    .w1c_i        (w1c),
    .w1c_data_i   (wdata_i[1:0]),
    .crc_err_i    (crc_err_i),
    .brownout_i   (brownout_i),
    .cfg_fault_i  (cfg_fault_i),
    .crc_flag_o   (crc_flag),
    .bor_flag_o   (bor_flag),
    .fault_flag_o (fault_flag)
  );

  cfg_cal_timer #(.CYCLES(CAL_CYCLES)) u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .req_i      (cal_req),
    .busy_o     (cal_busy)
  );

  assign status_byte = {1'b1, seq_active_i, 3'b000, fault_flag, crc_flag, bor_flag};

  always_comb begin
    rd = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_i == reg_addr(i)) rd = q_arr[i];
    end
    case (addr_i)
      A_STATUS: rd = status_byte;
      A_GEN:    rd = q_arr[I_GEN] | {6'b0, cal_busy, 1'b0};
      A_GPI:    rd = gpi_i;
      default:  ;
    endcase
  end
  assign rdata_o = rd;

  assign ref_en_o     = q_arr[I_GEN][7];
  assign crc_en_o     = q_arr[I_GEN][6];
  assign range_o      = q_arr[I_GEN][3];
  assign ch_force_o   = q_arr[I_GEN][2];
  assign cal_busy_o   = cal_busy;
  assign fix_pat_o    = q_arr[I_DATA][7];
  assign append_sel_o = q_arr[I_DATA][5:4];
  assign spi_mode_o   = q_arr[I_DATA][1:0];
  assign osr_o        = q_arr[I_OSR][2:0];
  assign osc_sel_o    = q_arr[I_OPM][4];
  assign clk_div_o    = q_arr[I_OPM][3:0];
  assign pin_cfg_o    = q_arr[I_PIN];
  assign gpio_dir_o   = q_arr[I_DIR];
  assign gpo_drive_o  = q_arr[I_DRV];
  assign gpo_val_o    = q_arr[I_GPO];
  assign seq_start_o  = q_arr[I_SEQ][4];
  assign seq_mode_o   = q_arr[I_SEQ][1:0];
  assign manual_ch_o  = q_arr[I_MCH][3:0];
  assign auto_ch_o    = q_arr[I_ACH];
  assign bitwalk_en_o = q_arr[I_DEN][0];
  assign vtest_en_o   = q_arr[I_DEN][4] && !q_arr[I_DEN][0];
  assign bit_sample_o = {q_arr[I_BSH], q_arr[I_BSL]};
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
  parameter int CAL_CYCLES = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic [7:0] addr_i,
  input logic [1:0] cmd_i,
  input logic [7:0] rdata_i,
  input logic       crc_err_i,
  input logic       crc_flag_i,
  input logic       bor_flag_i,
  input logic       cal_busy_i,
  input logic       diag_ok_i,
  input logic [7:0] pin_cfg_i,
  input logic [7:0] bsl_i
);
  int busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_run <= 0;
    else if (cal_busy_i) busy_run <= busy_run + 1;
    else                 busy_run <= 0;
  end

  AST_STATUS_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h00) |-> (rdata_i[7] && rdata_i[5:3] == 3'b000)); // R2

  AST_CRC_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_flag_i && we_i && addr_i == 8'h05) |=> $stable(pin_cfg_i)); // R4

  AST_SRST_SETS_BOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h01 && cmd_i[0] && !crc_err_i) |=> (bor_flag_i && !crc_flag_i)); // R5

  AST_CAL_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h01 && cmd_i == 2'b10 && !cal_busy_i) |=> cal_busy_i); // R6

  AST_CAL_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= CAL_CYCLES); // R6

  AST_DIAG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!diag_ok_i && we_i && addr_i == 8'hC1) |=> $stable(bsl_i)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h06) |-> (rdata_i == 8'h00)); // R9
endmodule

bind cfg_regbank cfg_regbank_chk #(.CAL_CYCLES(CAL_CYCLES)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .cmd_i      (wdata_i[1:0]),
  .rdata_i    (rdata_o),
  .crc_err_i  (crc_err_i),
  .crc_flag_i (crc_flag),
  .bor_flag_i (bor_flag),
  .cal_busy_i (cal_busy),
  .diag_ok_i  (diag_ok),
  .pin_cfg_i  (pin_cfg_o),
  .bsl_i      (bit_sample_o[7:0])
);

// File: tb/test_cfg_regbank.sv
`timescale 1ns/100ps
module test_cfg_regbank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, gpi = '0;
  logic        crc_ev = 1'b0, bor_ev = 1'b0, flt_ev = 1'b0, seq_act = 1'b0;
  logic [7:0]  rdata_o;
  logic        ref_en_o, crc_en_o, range_o, ch_force_o, cal_busy_o, fix_pat_o;
  logic [1:0]  append_sel_o, spi_mode_o, seq_mode_o;
  logic [2:0]  osr_o;
  logic        osc_sel_o, seq_start_o, bitwalk_en_o, vtest_en_o;
  logic [3:0]  clk_div_o, manual_ch_o;
  logic [7:0]  pin_cfg_o, gpio_dir_o, gpo_drive_o, gpo_val_o, auto_ch_o;
  logic [15:0] bit_sample_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cfg_regbank i_cfg_regbank (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_o), .crc_err_i(crc_ev), .brownout_i(bor_ev), .cfg_fault_i(flt_ev),
    .seq_active_i(seq_act), .gpi_i(gpi),
    .ref_en_o(ref_en_o), .crc_en_o(crc_en_o), .range_o(range_o), .ch_force_o(ch_force_o),
    .cal_busy_o(cal_busy_o), .fix_pat_o(fix_pat_o), .append_sel_o(append_sel_o),
    .spi_mode_o(spi_mode_o), .osr_o(osr_o), .osc_sel_o(osc_sel_o), .clk_div_o(clk_div_o),
    .pin_cfg_o(pin_cfg_o), .gpio_dir_o(gpio_dir_o), .gpo_drive_o(gpo_drive_o),
    .gpo_val_o(gpo_val_o), .seq_start_o(seq_start_o), .seq_mode_o(seq_mode_o),
    .manual_ch_o(manual_ch_o), .auto_ch_o(auto_ch_o), .bitwalk_en_o(bitwalk_en_o),
    .vtest_en_o(vtest_en_o), .bit_sample_o(bit_sample_o)
  );

  // behavioural reference state
  logic [7:0] mreg [256];
  bit m_crc, m_bor, m_fault, cal_on;
  int cal_left;

  function automatic logic [7:0] wmask(input int a);
    case (a)
      8'h01: return 8'hCC;
      8'h02: return 8'hB3;
      8'h03: return 8'h07;
      8'h04: return 8'h1F;
      8'h10: return 8'h13;
      8'h11: return 8'h0F;
      8'hC0: return 8'h11;
      8'h05, 8'h07, 8'h09, 8'h0B, 8'h12, 8'hBF, 8'hC1, 8'hC2: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mdefaults();
    for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
    mreg[8'h04] = 8'h01;
    m_crc = 0; m_fault = 0; m_bor = 1; cal_on = 0; cal_left = 0;
  endtask

  function automatic logic [7:0] mread(input int a);
    case (a)
      8'h00:   return {1'b1, seq_act, 3'b000, m_fault, m_crc, m_bor};
      8'h01:   return mreg[1] | {6'b0, cal_on, 1'b0};
      8'h0D:   return gpi;
      default: return mreg[a];
    endcase
  endfunction

  function automatic logic [127:0] mfields();
    logic [7:0] d0 = mreg[8'hC0];
    return {mreg[1][7], mreg[1][6], mreg[1][3], mreg[1][2], cal_on,
            mreg[2][7], mreg[2][5:4], mreg[2][1:0], mreg[3][2:0], mreg[4][4], mreg[4][3:0],
            mreg[5], mreg[7], mreg[9], mreg[8'h0B],
            mreg[8'h10][4], mreg[8'h10][1:0], mreg[8'h11][3:0], mreg[8'h12],
            d0[0], d0[4] & ~d0[0], mreg[8'hC2], mreg[8'hC1]};
  endfunction

  function automatic logic [127:0] dfields();
    return {ref_en_o, crc_en_o, range_o, ch_force_o, cal_busy_o,
            fix_pat_o, append_sel_o, spi_mode_o, osr_o, osc_sel_o, clk_div_o,
            pin_cfg_o, gpio_dir_o, gpo_drive_o, gpo_val_o,
            seq_start_o, seq_mode_o, manual_ch_o, auto_ch_o,
            bitwalk_en_o, vtest_en_o, bit_sample_o};
  endfunction

  task automatic mstep();
    int a = int'(addr);
    logic [7:0] d = wdata;
    bit key_ok = (mreg[8'hBF] == 8'h96);
    bit ok = we && (!m_crc || a == 0 || a == 1);
    if (ok && a == 1 && d[0]) begin
      mdefaults();
    end else begin
      if (cal_on) begin
        cal_left--;
        if (cal_left == 0) cal_on = 0;
      end else if (ok && a == 1 && d[1]) begin
        cal_on = 1; cal_left = 16;
      end
      if (ok) begin
        if (a == 0) begin
          if (d[1]) m_crc = 0;
          if (d[0]) m_bor = 0;
        end else if (!(a >= 8'hC0 && a <= 8'hC2) || key_ok) begin
          mreg[a] = d & wmask(a);
        end
      end
    end
    if (crc_ev) m_crc = 1;
    if (bor_ev) m_bor = 1;
    if (flt_ev) m_fault = 1;
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one cycle: inputs held across the rising edge, model stepped there, compare at falling edge
  task automatic cyc(input logic w, input logic [7:0] a, input logic [7:0] d);
    we = w; addr = a; wdata = d;
    @(posedge clk);
    mstep();
    @(negedge clk);
    crc_ev = 0; bor_ev = 0; flt_ev = 0;
    chk("R10 rdata", rdata_o, mread(int'(addr)));
    chk("R11 fields", dfields(), mfields());
    we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    cyc(1'b0, a, 8'h00);
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi;
    mdefaults();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    rd_chk("R1 status", 8'h00, 8'h81);
    rd_chk("R1 opmode", 8'h04, 8'h01);
    rd_chk("R1 auto", 8'h12, 8'h00);
    rd_chk("R1 gen", 8'h01, 8'h00);

    // R2 status layout and event pulses
    seq_act = 1; flt_ev = 1; crc_ev = 1;
    rd_chk("R2 flags set", 8'h00, 8'hC7);
    seq_act = 0;
    rd_chk("R2 seq low", 8'h00, 8'h87);

    // R3 write-one-to-clear
    cyc(1'b1, 8'h00, 8'h00);
    rd_chk("R3 zero keeps", 8'h00, 8'h87);
    crc_ev = 1;
    cyc(1'b1, 8'h00, 8'h02);
    rd_chk("R2 set beats clear", 8'h00, 8'h87);
    cyc(1'b1, 8'h00, 8'h03);
    rd_chk("R3 cleared, fault kept", 8'h00, 8'h84);

    // R4 crc error blocks writes
    crc_ev = 1;
    cyc(1'b0, 8'h00, 8'h00);
    cyc(1'b1, 8'h05, 8'hFF);
    rd_chk("R4 blocked", 8'h05, 8'h00);
    cyc(1'b1, 8'h01, 8'hC0);
    rd_chk("R4 gen allowed", 8'h01, 8'hC0);
    cyc(1'b1, 8'h00, 8'h02);
    cyc(1'b1, 8'h05, 8'hFF);
    rd_chk("R4 unblocked", 8'h05, 8'hFF);

    // R5 software reset
    cyc(1'b1, 8'h04, 8'h1A);
    cyc(1'b1, 8'h00, 8'h01);
    cyc(1'b1, 8'h01, 8'hCF);
    rd_chk("R5 status", 8'h00, 8'h81);
    rd_chk("R5 gen", 8'h01, 8'h00);
    rd_chk("R5 pin", 8'h05, 8'h00);
    rd_chk("R5 opmode", 8'h04, 8'h01);

    // R6 calibration length
    cyc(1'b1, 8'h01, 8'h02);
    chk("R6 rdata busy", rdata_o, 8'h02);
    hi = cal_busy_o ? 1 : 0;
    for (int k = 0; k < 20; k++) begin
      cyc(1'b0, 8'h01, 8'h00);
      if (cal_busy_o) hi++;
    end
    chk("R6 busy cycles", hi, 16);
    cyc(1'b1, 8'h01, 8'h02);
    hi = 1;
    for (int k = 0; k < 5; k++) begin
      cyc(1'b0, 8'h01, 8'h00);
      if (cal_busy_o) hi++;
    end
    cyc(1'b1, 8'h01, 8'h02);
    if (cal_busy_o) hi++;
    for (int k = 0; k < 20; k++) begin
      cyc(1'b0, 8'h01, 8'h00);
      if (cal_busy_o) hi++;
    end
    chk("R6 no extend", hi, 16);

    // R7 diagnostics key
    cyc(1'b1, 8'hC1, 8'h5A);
    rd_chk("R7 locked", 8'hC1, 8'h00);
    cyc(1'b1, 8'hBF, 8'h96);
    cyc(1'b1, 8'hC1, 8'h5A);
    rd_chk("R7 unlocked", 8'hC1, 8'h5A);
    cyc(1'b1, 8'hBF, 8'h97);
    cyc(1'b1, 8'hC2, 8'h33);
    rd_chk("R7 relocked", 8'hC2, 8'h00);

    // R8 reserved masks and R11 test-voltage gating
    cyc(1'b1, 8'h02, 8'hFF);
    rd_chk("R8 data mask", 8'h02, 8'hB3);
    cyc(1'b1, 8'h10, 8'hFF);
    rd_chk("R8 seq mask", 8'h10, 8'h13);
    cyc(1'b1, 8'hBF, 8'h96);
    cyc(1'b1, 8'hC0, 8'hFF);
    rd_chk("R8 diag mask", 8'hC0, 8'h11);
    chk("R11 vtest off under bitwalk", vtest_en_o, 1'b0);
    cyc(1'b1, 8'hC0, 8'h10);
    chk("R11 vtest on", vtest_en_o, 1'b1);

    // R9 unmapped / read-only, R10 live gpi
    cyc(1'b1, 8'h06, 8'hFF);
    rd_chk("R9 unmapped", 8'h06, 8'h00);
    gpi = 8'hA5;
    cyc(1'b1, 8'h0D, 8'h00);
    chk("R9 gpi read-only", rdata_o, 8'hA5);
    gpi = 8'h3C;
    #1;
    chk("R10 gpi live", rdata_o, 8'h3C);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] alist [19] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h09,
                                 8'h0B, 8'h0D, 8'h10, 8'h11, 8'h12, 8'hBF, 8'hC0, 8'hC1, 8'hC2, 8'h55};
      logic [7:0] a = alist[$urandom_range(0, 18)];
      logic [7:0] d = 8'($urandom);
      if (a == 8'h01 && $urandom_range(0, 15) != 0) d[0] = 1'b0;
      if (a == 8'hBF && $urandom_range(0, 1) == 0) d = 8'h96;
      crc_ev  = ($urandom_range(0, 29) == 0);
      bor_ev  = ($urandom_range(0, 39) == 0);
      flt_ev  = ($urandom_range(0, 59) == 0);
      seq_act = 1'($urandom);
      gpi     = 8'($urandom);
      cyc(1'($urandom), a, d);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule